// File: doc/BRIEF.md
# Banked Register Window Decoder

This block sits between a generic host bus and a peripheral's banked register file. The host presents accesses of one, two or four bytes. Each access either falls inside a 32-byte window whose position is set by a programmable base address, or it is dropped. Inside the window, one byte-wide doubleword slot is shared by every bank. It holds the bank number, a 6-bit value that picks one of 64 register banks. Every other location is forwarded to the register file, together with the current bank number, a doubleword-aligned offset and per-byte lane enables. The base address itself is also stored here. It sits at the start of bank 0 and can be rewritten by the host. After reset it takes either a fixed default or a value delivered by an external loader, depending on a strap pin.

Requests arrive on a valid/ready channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held and `rsp_ready` is low, so a stalled response back-pressures the request side. A claimed request produces exactly one response beat one cycle after it is taken. That beat is read data for a read and zero for a write. A request that misses the window, or has an illegal size or alignment, is taken and discarded with no response. The register-file strobes are combinational in the cycle the request is taken, and `rf_rdata` is expected back in that same cycle.

Top module: `bank_window_dec`

## Requirements
- R1: A request is claimed only when address bits [15:8] equal the stored high base field and address bits [7:5] equal the stored 3-bit low base field. A non-matching request is taken, produces no response and raises no register-file strobe.
- R2: After reset the base is 0x0300 (high field 0x03, low field 0) whatever the strap, the bank number is 0, no response is pending and `req_ready` is high.
- R3: With `strap_load` high, a `ld_valid` pulse replaces the base with `ld_base` (address bits [15:5]) from the next cycle. With the strap low the pulse is ignored. A loader pulse overrides a host write to the base in the same cycle, and the loader has no way to be written back.
- R4: In bank 0, byte 0x00 bits [7:5] and byte 0x01 hold the low and high base fields. Bits [4:0] of byte 0x00 read zero. A write there moves the window from the next request on. In other banks, offsets 0x00–0x01 are forwarded.
- R5: The bank number lives in bits [5:0] of byte 0x0E in every bank. It can be read or written as a byte or a word at 0x0E, or as a doubleword at 0x0C, where it is lane 2, data bits [21:16].
- R6: Bits [7:6] of byte 0x0E and all of bytes 0x0C, 0x0D and 0x0F read zero and ignore writes. No access to 0x0C–0x0F is forwarded, so a doubleword write at 0x0C changes only the bank number.
- R7: Other claimed accesses are forwarded with `rf_bank` equal to the bank number and `rf_offs` equal to the address bits [4:2] followed by two zeros. The lane enables follow the size code: 0 is a byte with lane address[1:0]; 1 is a word with lanes address[1:0] and address[1:0]+1; 2 is a doubleword with all lanes. Lane n is data bits [8n+7:8n].
- R8: A word at an odd address, a doubleword not at a multiple of four, or size code 3 gets no response and no strobe.
- R9: `rf_wr` or `rf_rd` is high for exactly the one cycle in which a forwarded write or read is taken. The response comes in the next cycle, and its lanes that were not requested are zero.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response holds its data, `req_ready` is low and no request is taken or forwarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_load | input | 1 | High: base comes from the loader |
| ld_valid | input | 1 | Loader delivers a base value this cycle |
| ld_base | input | 11 | Base address bits [15:5] from the loader |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken when high together with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 doubleword |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data, lane n at bits [8n+7:8n] |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Host accepts the response |
| rsp_data | output | 32 | Read data, zero for writes |
| rf_wr | output | 1 | Register-file write strobe |
| rf_rd | output | 1 | Register-file read strobe |
| rf_bank | output | 6 | Selected bank |
| rf_offs | output | 5 | Doubleword-aligned offset in the window |
| rf_be | output | 4 | Lane enables of the forwarded part |
| rf_wdata | output | 32 | Write data to the register file |
| rf_rdata | input | 32 | Register-file read data, same cycle |

## Verification
Two functions can meet in one clock edge. One is a host write to the base register. The other is a loader pulse with the strap high. The bench drives both in the same cycle, with different base values. It then judges the result by which window answers: the loaded window must respond and the host-written window must not. A second collision is a stalled response meeting a new request that would be forwarded. Here the bench checks that no strobe appears until `rsp_ready` rises. It then checks that the held data stays unchanged, and that the queued request is forwarded and answered in the cycles that follow.

// File: rtl/bwd_pkg.sv
package bwd_pkg;
  localparam int ADDR_W    = 16;
  localparam int OFFS_W    = 5;
  localparam int BANK_W    = 6;
  localparam int LANES     = 4;
  localparam int DATA_W    = 8 * LANES;
  localparam int LO_W      = 8 - OFFS_W;
  localparam int HI_W      = ADDR_W - 8;
  localparam int BASE_W    = HI_W + LO_W;
  localparam int DW_W      = OFFS_W - 2;
  localparam int BSR_LANE  = 2;
  localparam logic [DW_W-1:0] SHARED_DW = DW_W'(3);
  localparam logic [HI_W-1:0] RST_HI    = HI_W'(8'h03);
  localparam logic [LO_W-1:0] RST_LO    = '0;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_BAD   = 2'd3
  } size_e;
endpackage

// File: rtl/bwd_addr_match.sv
module bwd_addr_match
  import bwd_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [HI_W-1:0]   base_hi,
  input  logic [LO_W-1:0]   base_lo,
  output logic              hit,
  output logic              legal,
  output logic [LANES-1:0]  lanes,
  output logic [DW_W-1:0]   dw
);
  // window compare is split: high byte and the bits just above the offset
  always_comb begin
    hit = (addr[ADDR_W-1:8] == base_hi) && (addr[7:OFFS_W] == base_lo);
    dw  = addr[OFFS_W-1:2];
    case (size_e'(size))
      SZ_BYTE: begin
        legal = 1'b1;
        lanes = LANES'(1) << addr[1:0];
      end
      SZ_WORD: begin
        legal = !addr[0];
        lanes = LANES'(3) << {addr[1], 1'b0};
      end
      SZ_DWORD: begin
        legal = (addr[1:0] == 2'b00);
        lanes = '1;
      end
      default: begin
        legal = 1'b0;
        lanes = '0;
      end
    endcase
  end
endmodule

// File: rtl/bwd_lane_route.sv
module bwd_lane_route
  import bwd_pkg::*;
(
  input  logic [DW_W-1:0]   dw,
  input  logic [BANK_W-1:0] bank,
  input  logic [HI_W-1:0]   base_hi,
  input  logic [LO_W-1:0]   base_lo,
  input  logic [LANES-1:0]  lanes,
  output logic              is_shared,
  output logic              is_bar,
  output logic [LANES-1:0]  own,
  output logic [LANES-1:0]  fwd,
  output logic [DATA_W-1:0] loc_rdata
);
  // lanes kept locally never reach the register file
  always_comb begin
    is_shared = (dw == SHARED_DW);
    is_bar    = (dw == '0) && (bank == '0);
    if (is_shared)   own = '1;
    else if (is_bar) own = LANES'(3);
    else             own = '0;
    fwd = lanes & ~own;

    loc_rdata = '0;
    if (is_shared)
      loc_rdata[8*BSR_LANE +: 8] = {{(8 - BANK_W){1'b0}}, bank};
    else if (is_bar)
      loc_rdata[15:0] = {base_hi, base_lo, {OFFS_W{1'b0}}};
  end
endmodule

// File: rtl/bwd_local_regs.sv
module bwd_local_regs
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_load,
  input  logic              ld_valid,
  input  logic [BASE_W-1:0] ld_base,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_bank,
  input  logic [LO_W-1:0]   wd_lo,
  input  logic [HI_W-1:0]   wd_hi,
  input  logic [BANK_W-1:0] wd_bank,
  output logic [HI_W-1:0]   base_hi,
  output logic [LO_W-1:0]   base_lo,
  output logic [BANK_W-1:0] bank
);
  always_ff @(posedge clk) begin
    if (rst) begin
      base_hi <= RST_HI;
      base_lo <= RST_LO;
      bank    <= '0;
    end else begin
      // the loader outranks a host write landing in the same cycle
      if (strap_load && ld_valid) begin
        {base_hi, base_lo} <= ld_base;
      end else begin
        if (wr_lo) base_lo <= wd_lo;
        if (wr_hi) base_hi <= wd_hi;
      end
      if (wr_bank) bank <= wd_bank;
    end
  end

  p_loader_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (strap_load && ld_valid) |=> ({base_hi, base_lo} == $past(ld_base)));

  p_strap_low_ignores_r3: assert property (@(posedge clk) disable iff (rst)
    (!strap_load && !wr_lo && !wr_hi) |=> ($stable(base_hi) && $stable(base_lo)));
endmodule

// File: rtl/bank_window_dec.sv
module bank_window_dec
  import bwd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_load,
  input  logic              ld_valid,
  input  logic [BASE_W-1:0] ld_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rf_wr,
  output logic              rf_rd,
  output logic [BANK_W-1:0] rf_bank,
  output logic [OFFS_W-1:0] rf_offs,
  output logic [LANES-1:0]  rf_be,
  output logic [DATA_W-1:0] rf_wdata,
  input  logic [DATA_W-1:0] rf_rdata
);
  logic              hit, legal;
  logic [LANES-1:0]  lanes, own, fwd;
  logic [DW_W-1:0]   dw;
  logic              is_shared, is_bar;
  logic [DATA_W-1:0] loc_rdata, rd_merge;
  logic [HI_W-1:0]   base_hi;
  logic [LO_W-1:0]   base_lo;
  logic [BANK_W-1:0] bank;
  logic              take, claim, fwd_any, wr_local;

  bwd_addr_match u_match (
    .addr(req_addr), .size(req_size), .base_hi(base_hi), .base_lo(base_lo),
    .hit(hit), .legal(legal), .lanes(lanes), .dw(dw)
  );

  bwd_lane_route u_route (
    .dw(dw), .bank(bank), .base_hi(base_hi), .base_lo(base_lo), .lanes(lanes),
    .is_shared(is_shared), .is_bar(is_bar), .own(own), .fwd(fwd),
    .loc_rdata(loc_rdata)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign take      = req_valid && req_ready;
  assign claim     = take && hit && legal;
  assign fwd_any   = |fwd;
  assign wr_local  = claim && req_write;

  bwd_local_regs u_regs (
    .clk(clk), .rst(rst), .strap_load(strap_load), .ld_valid(ld_valid),
    .ld_base(ld_base),
    .wr_lo(wr_local && is_bar && lanes[0]),
    .wr_hi(wr_local && is_bar && lanes[1]),
    .wr_bank(wr_local && is_shared && lanes[BSR_LANE]),
    .wd_lo(req_wdata[7:OFFS_W]),
    .wd_hi(req_wdata[15:8]),
    .wd_bank(req_wdata[8*BSR_LANE +: BANK_W]),
    .base_hi(base_hi), .base_lo(base_lo), .bank(bank)
  );

  assign rf_wr    = claim && req_write && fwd_any;
  assign rf_rd    = claim && !req_write && fwd_any;
  assign rf_be    = (rf_wr || rf_rd) ? fwd : '0;
  assign rf_bank  = bank;
  assign rf_offs  = {dw, 2'b00};
  assign rf_wdata = req_wdata;

  // per lane: unrequested lanes zero, owned lanes local, the rest from the file
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_merge[8*l +: 8] = !lanes[l] ? 8'h00 :
                                own[l]    ? loc_rdata[8*l +: 8] :
                                            rf_rdata[8*l +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (claim) begin
      rsp_valid <= 1'b1;
      rsp_data  <= req_write ? '0 : rd_merge;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  p_stall_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> (!rf_wr && !rf_rd));

  p_strobe_answered_r9: assert property (@(posedge clk) disable iff (rst)
    (rf_wr || rf_rd) |=> rsp_valid);

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    !(rf_wr && rf_rd));

  p_shared_kept_r6: assert property (@(posedge clk) disable iff (rst)
    (rf_wr || rf_rd) |-> (rf_offs[OFFS_W-1:2] != SHARED_DW));

  p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready && req_write) |=> $stable(bank));

  p_lanes_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    (rf_wr || rf_rd) |-> (rf_be != '0));
endmodule

// File: tb/test_bank_window_dec.sv
module test_bank_window_dec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_load = 1'b0;
  logic        ld_valid = 1'b0;
  logic [10:0] ld_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_data;
  logic        rf_wr, rf_rd;
  logic [5:0]  rf_bank;
  logic [4:0]  rf_offs;
  logic [3:0]  rf_be;
  logic [31:0] rf_wdata, rf_rdata;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  // register-file model: contents encode bank and offset
  assign rf_rdata = {2'b01, rf_bank, 3'b000, rf_offs, 16'hC3A5};

  bank_window_dec i_bank_window_dec (
    .clk(clk), .rst(rst), .strap_load(strap_load), .ld_valid(ld_valid),
    .ld_base(ld_base), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rf_wr(rf_wr), .rf_rd(rf_rd), .rf_bank(rf_bank),
    .rf_offs(rf_offs), .rf_be(rf_be), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        wr;
    logic [1:0]  sz;
    logic [15:0] addr;
    logic [31:0] wd;
    logic        rsp;
    logic [31:0] rd;
    logic        stb;
    logic [3:0]  be;
    logic [5:0]  bank;
    logic [4:0]  offs;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{4'd4, 1'b0, 2'd2, 16'h0300, 32'h0,         1'b1, 32'h4000_0300, 1'b1, 4'b1100, 6'd0,  5'd0},  // R4
    '{4'd5, 1'b1, 2'd0, 16'h030E, 32'h0005_0000, 1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R5
    '{4'd5, 1'b0, 2'd2, 16'h030C, 32'h0,         1'b1, 32'h0005_0000, 1'b0, 4'b0000, 6'd0,  5'd0},  // R5
    '{4'd7, 1'b0, 2'd2, 16'h0304, 32'h0,         1'b1, 32'h4504_C3A5, 1'b1, 4'b1111, 6'd5,  5'd4},  // R7
    '{4'd4, 1'b0, 2'd0, 16'h0301, 32'h0,         1'b1, 32'h0000_C300, 1'b1, 4'b0010, 6'd5,  5'd0},  // R4
    '{4'd6, 1'b1, 2'd2, 16'h030C, 32'hFF2A_FFFF, 1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R6
    '{4'd5, 1'b0, 2'd1, 16'h030E, 32'h0,         1'b1, 32'h002A_0000, 1'b0, 4'b0000, 6'd0,  5'd0},  // R5
    '{4'd6, 1'b0, 2'd2, 16'h030C, 32'h0,         1'b1, 32'h002A_0000, 1'b0, 4'b0000, 6'd0,  5'd0},  // R6
    '{4'd7, 1'b1, 2'd1, 16'h031A, 32'h1234_0000, 1'b1, 32'h0,         1'b1, 4'b1100, 6'd42, 5'd24}, // R7
    '{4'd7, 1'b0, 2'd2, 16'h031C, 32'h0,         1'b1, 32'h6A1C_C3A5, 1'b1, 4'b1111, 6'd42, 5'd28}, // R7
    '{4'd1, 1'b0, 2'd2, 16'h0400, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R1
    '{4'd1, 1'b0, 2'd2, 16'h0320, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R1
    '{4'd8, 1'b0, 2'd1, 16'h0303, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R8
    '{4'd8, 1'b0, 2'd2, 16'h0302, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R8
    '{4'd8, 1'b0, 2'd3, 16'h0304, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R8
    '{4'd6, 1'b1, 2'd0, 16'h030F, 32'hFF00_0000, 1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R6
    '{4'd6, 1'b0, 2'd0, 16'h030E, 32'h0,         1'b1, 32'h002A_0000, 1'b0, 4'b0000, 6'd0,  5'd0},  // R6
    '{4'd6, 1'b0, 2'd0, 16'h030F, 32'h0,         1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R6
    '{4'd5, 1'b1, 2'd0, 16'h030E, 32'h0,         1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R5
    '{4'd4, 1'b1, 2'd1, 16'h0300, 32'h0000_127F, 1'b1, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R4
    '{4'd4, 1'b0, 2'd1, 16'h0300, 32'h0,         1'b0, 32'h0,         1'b0, 4'b0000, 6'd0,  5'd0},  // R4
    '{4'd4, 1'b0, 2'd1, 16'h1260, 32'h0,         1'b1, 32'h0000_1260, 1'b0, 4'b0000, 6'd0,  5'd0},  // R4
    '{4'd9, 1'b0, 2'd0, 16'h1263, 32'h0,         1'b1, 32'h4000_0000, 1'b1, 4'b1000, 6'd0,  5'd0}   // R9
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  // one request with rsp_ready high; strobes sampled in the take cycle,
  // the response one cycle later
  task automatic apply(input logic wr, input logic [1:0] sz, input logic [15:0] a,
                       input logic [31:0] wd,
                       output logic s_wr, output logic s_rd, output logic [3:0] s_be,
                       output logic [5:0] s_bank, output logic [4:0] s_offs,
                       output logic [31:0] s_wd, output logic o_rv,
                       output logic [31:0] o_rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    rsp_ready = 1'b1;
    #1;
    s_wr = rf_wr; s_rd = rf_rd; s_be = rf_be; s_bank = rf_bank; s_offs = rf_offs;
    s_wd = rf_wdata;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    o_rv = rsp_valid; o_rd = rsp_data;
  endtask

  task automatic read_expect(input string req, input logic [1:0] sz,
                             input logic [15:0] a, input logic exp_rv,
                             input logic [31:0] exp_rd);
    logic w, r, rv;
    logic [3:0] be;
    logic [5:0] bk;
    logic [4:0] of;
    logic [31:0] wdo, rd;
    apply(1'b0, sz, a, 32'h0, w, r, be, bk, of, wdo, rv, rd);
    chk(req, "rsp_valid", {31'b0, rv}, {31'b0, exp_rv});
    if (exp_rv) chk(req, "rsp_data", rd, exp_rd);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_up();
  end

  initial begin
    logic w, r, rv;
    logic [3:0] be;
    logic [5:0] bk;
    logic [4:0] of;
    logic [31:0] wdo, rd;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // reset state, R2
    chk("R2", "rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    chk("R2", "req_ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R2", "strobes after reset", {30'b0, rf_wr, rf_rd}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VECS[i].req, i);
      apply(VECS[i].wr, VECS[i].sz, VECS[i].addr, VECS[i].wd,
            w, r, be, bk, of, wdo, rv, rd);
      chk(tag, "rsp_valid", {31'b0, rv}, {31'b0, VECS[i].rsp});
      if (VECS[i].rsp) chk(tag, "rsp_data", rd, VECS[i].rd);
      chk(tag, "rf_wr", {31'b0, w}, {31'b0, VECS[i].stb && VECS[i].wr});
      chk(tag, "rf_rd", {31'b0, r}, {31'b0, VECS[i].stb && !VECS[i].wr});
      if (VECS[i].stb) begin
        chk(tag, "rf_be", {28'b0, be}, {28'b0, VECS[i].be});
        chk(tag, "rf_bank", {26'b0, bk}, {26'b0, VECS[i].bank});
        chk(tag, "rf_offs", {27'b0, of}, {27'b0, VECS[i].offs});
        if (VECS[i].wr) chk(tag, "rf_wdata", wdo, VECS[i].wd);
      end
    end

    // back-pressure, R10: base is 0x1260, bank 0
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd1; req_addr = 16'h1260;
    @(posedge clk);
    @(negedge clk);
    req_size = 2'd2; req_addr = 16'h1264;
    #1;
    chk("R10", "req_ready while stalled", {31'b0, req_ready}, 32'd0);
    chk("R10", "rf_rd while stalled", {31'b0, rf_rd}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk("R10", "rsp_valid held", {31'b0, rsp_valid}, 32'd1);
    chk("R10", "rsp_data held", rsp_data, 32'h0000_1260);
    rsp_ready = 1'b1;
    #1;
    chk("R9", "rf_rd on release", {31'b0, rf_rd}, 32'd1);
    chk("R9", "rf_offs on release", {27'b0, rf_offs}, 32'd4);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "queued rsp_valid", {31'b0, rsp_valid}, 32'd1);
    chk("R9", "queued rsp_data", rsp_data, 32'h4004_C3A5);
    @(negedge clk);
    chk("R9", "single response", {31'b0, rsp_valid}, 32'd0);

    // loader, R3: strap low ignores the pulse
    @(negedge clk);
    ld_valid = 1'b1; ld_base = 11'h55E;
    @(negedge clk);
    ld_valid = 1'b0;
    read_expect("R3", 2'd1, 16'h1260, 1'b1, 32'h0000_1260);
    strap_load = 1'b1;
    @(negedge clk);
    ld_valid = 1'b1; ld_base = 11'h029;   // 0x0520
    @(negedge clk);
    ld_valid = 1'b0;
    read_expect("R3", 2'd1, 16'h0520, 1'b1, 32'h0000_0520);
    // loader and host base write in one cycle
    @(negedge clk);
    ld_valid = 1'b1; ld_base = 11'h04A;   // 0x0940
    req_valid = 1'b1; req_write = 1'b1; req_size = 2'd1; req_addr = 16'h0520;
    req_wdata = 32'h0000_7700;
    @(posedge clk);
    @(negedge clk);
    ld_valid = 1'b0; req_valid = 1'b0;
    chk("R3", "collision write answered", {31'b0, rsp_valid}, 32'd1);
    read_expect("R3", 2'd1, 16'h0940, 1'b1, 32'h0000_0940);
    read_expect("R3", 2'd1, 16'h7700, 1'b0, 32'h0);

    // reset with strap high still gives the default base and bank 0, R2
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    read_expect("R2", 2'd1, 16'h0300, 1'b1, 32'h0000_0300);
    read_expect("R2", 2'd0, 16'h030E, 1'b1, 32'h0);

    finish_up();
  end
endmodule